// File: doc/BRIEF.md
# Loss-of-Signal Detector with Data Gating

This block watches a serial receive bit stream for level changes between consecutive bits. A long stretch with no change raises a loss-of-signal flag. The flag drops again only once a full window of bits shows enough changes. Entry and exit therefore use different criteria, which gives hysteresis.

An optical module's signal-detect output can also force the flag. Its active level is set by a polarity-select pin. While the flag is up, the data handed downstream is held at zero, so later stages see a dead line rather than noise. The bits move through a one-stage valid/ready register. A bit counts toward detection only in a cycle where it is accepted.

Upstream may hold `in_valid` high and change nothing while `in_ready` is low. Downstream stalls the stream by lowering `out_ready`. The output bit is then kept until it is taken, and no new bit is accepted unless the output register is empty or is being drained in that same cycle.

Top module: `los_detect`

## Requirements
- R1: With the internal detector enabled, `los_flag` rises after the accepted bit that completes a run of 129 consecutive accepted bits that show no transition (more than RUN_LIMIT=128). A run of exactly 128 leaves it low.
- R2: While internal LOS is active, it clears at the end of a window of 128 accepted bits only if that window held more than 16 transitions. Exactly 16 transitions keep LOS active.
- R3: Recovery windows do not overlap. The first window starts with the first accepted bit after LOS rises, and each later window starts right after the previous one ends, with the transition count restarted.
- R4: Whenever `los_flag` is 1, `out_bit` is 0. Otherwise `out_bit` equals the last accepted input bit.
- R5: While `det_en_n` is 1, the internal detector is off: internal LOS is cleared and its run and window counts restart.
- R6: The external term is active when `pol_sel` XNOR `sd_flag` equals 1, so 00 and 11 are active and 01 and 10 are not. `los_flag` is the OR of the internal result and this term, and the external term acts in the same cycle.
- R7: A transition is an accepted bit that differs from the previously accepted bit. The previous bit resets to 0.
- R8: After reset, internal LOS is inactive and `out_valid` is 0.
- R9: `in_ready` = !`out_valid` || `out_ready`. A bit is accepted only when `in_valid` and `in_ready` are both 1. While `out_valid` is 1 and `out_ready` is 0, the output stays valid and holds its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Asynchronous reset, active high |
| det_en_n | input | 1 | Internal detector enable, active low |
| pol_sel | input | 1 | Polarity select for the optics flag |
| sd_flag | input | 1 | Optics signal-detect flag |
| in_valid | input | 1 | Input bit valid |
| in_ready | output | 1 | Block can accept a bit |
| in_bit | input | 1 | Serial input bit |
| out_valid | output | 1 | Output bit valid |
| out_ready | input | 1 | Downstream can take the output bit |
| out_bit | output | 1 | Gated output bit |
| los_flag | output | 1 | Loss-of-signal indication |

## Verification
A constant stream of zeros straight after reset shows whether the raise threshold sits at 128 or 129 bits. Recovery windows with exactly 16 and then 17 toggles in their opening bits separate the "more than" rule from "at least", and check that the window starts at the first bit after LOS rises. All four polarity/flag combinations and a long idle stretch with the detector disabled are applied in turn. Seeded random traffic then mixes segments of very low and high transition density with random stalls on both sides of the handshake, so that uncounted cycles would show up as a drift against the bench's own model.

// File: rtl/los_pkg.sv
package los_pkg;
  typedef enum logic {
    LOS_CLEAR = 1'b0,
    LOS_DOWN  = 1'b1
  } los_state_e;

  // external term is active when both inputs agree
  function automatic logic ext_active(input logic pol, input logic flag);
    return ~(pol ^ flag);
  endfunction
endpackage

// File: rtl/los_edge_tracker.sv
module los_edge_tracker (
  input  logic clk,
  input  logic rst,
  input  logic beat,
  input  logic bit_in,
  output logic edge_seen
);
  logic prev_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)       prev_q <= 1'b0;
    else if (beat) prev_q <= bit_in;
  end

  assign edge_seen = beat && (bit_in != prev_q);

  // R7: the reference bit follows each accepted bit
  a_r7_prev_follows: assert property (@(posedge clk) disable iff (rst)
    beat |=> (prev_q == $past(bit_in)));
endmodule

// File: rtl/los_run_monitor.sv
module los_run_monitor #(
  parameter int RUN_LIMIT = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic beat,
  input  logic edge_seen,
  output logic expire
);
  localparam int CW = $clog2(RUN_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(RUN_LIMIT);

  logic [CW-1:0] run_q;

  assign expire = armed && beat && !edge_seen && (run_q == LIM);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)             run_q <= '0;
    else if (!armed)     run_q <= '0;
    else if (beat) begin
      if (edge_seen)     run_q <= '0;
      else if (run_q != LIM) run_q <= run_q + 1'b1;
    end
  end

  a_r1_run_bounded: assert property (@(posedge clk) disable iff (rst)
    run_q <= LIM);
  a_r1_edge_restarts: assert property (@(posedge clk) disable iff (rst)
    (armed && edge_seen) |=> (run_q == '0));
endmodule

// File: rtl/los_recovery_window.sv
module los_recovery_window #(
  parameter int WINDOW    = 128,
  parameter int MIN_EDGES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic beat,
  input  logic edge_seen,
  output logic recovered
);
  localparam int BW = $clog2(WINDOW);
  localparam int EW = $clog2(WINDOW + 1);
  localparam logic [BW-1:0] LAST = BW'(WINDOW - 1);
  localparam logic [EW-1:0] NEED = EW'(MIN_EDGES);

  logic [BW-1:0] blk_q;
  logic [EW-1:0] edg_q;
  logic [EW-1:0] edg_next;
  logic          last_beat;

  assign last_beat = beat && (blk_q == LAST);
  assign edg_next  = edg_q + EW'(edge_seen);
  assign recovered = active && last_beat && (edg_next > NEED);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      blk_q <= '0;
      edg_q <= '0;
    end else if (!active) begin
      blk_q <= '0;
      edg_q <= '0;
    end else if (beat) begin
      if (last_beat) begin
        blk_q <= '0;
        edg_q <= '0;
      end else begin
        blk_q <= blk_q + 1'b1;
        edg_q <= edg_next;
      end
    end
  end

  // R2: edges within a window never outnumber the bits seen
  a_r2_edges_within_bits: assert property (@(posedge clk) disable iff (rst)
    edg_q <= EW'(blk_q));
  // R3: each window restarts from zero
  a_r3_window_restart: assert property (@(posedge clk) disable iff (rst)
    (active && last_beat) |=> (blk_q == '0 && edg_q == '0));
endmodule

// File: rtl/los_out_stage.sv
module los_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  output logic beat,
  input  logic gate,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit
);
  logic hold_q;
  logic ov_q;

  assign in_ready  = !ov_q || out_ready;
  assign beat      = in_valid && in_ready;
  assign out_valid = ov_q;
  assign out_bit   = hold_q & ~gate;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      hold_q <= 1'b0;
      ov_q   <= 1'b0;
    end else if (beat) begin
      hold_q <= in_bit;
      ov_q   <= 1'b1;
    end else if (out_ready) begin
      ov_q   <= 1'b0;
    end
  end

  a_r9_stall_holds: assert property (@(posedge clk) disable iff (rst)
    (ov_q && !out_ready) |=> (ov_q && $stable(hold_q)));
endmodule

// File: rtl/los_detect.sv
module los_detect #(
  parameter int RUN_LIMIT = 128,
  parameter int WINDOW    = 128,
  parameter int MIN_EDGES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic det_en_n,
  input  logic pol_sel,
  input  logic sd_flag,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic los_flag
);
  import los_pkg::*;

  los_state_e state_q;
  logic beat, edge_seen, expire, recovered;
  logic en, los_int, armed, active, ext_los;

  assign en      = !det_en_n;
  assign los_int = (state_q == LOS_DOWN);
  assign armed   = en && !los_int;
  assign active  = en && los_int;
  assign ext_los = ext_active(pol_sel, sd_flag);
  assign los_flag = los_int | ext_los;

  los_out_stage u_out (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .beat(beat), .gate(los_flag),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit)
  );

  los_edge_tracker u_edge (
    .clk(clk), .rst(rst), .beat(beat), .bit_in(in_bit), .edge_seen(edge_seen)
  );

  los_run_monitor #(.RUN_LIMIT(RUN_LIMIT)) u_run (
    .clk(clk), .rst(rst), .armed(armed), .beat(beat),
    .edge_seen(edge_seen), .expire(expire)
  );

  los_recovery_window #(.WINDOW(WINDOW), .MIN_EDGES(MIN_EDGES)) u_win (
    .clk(clk), .rst(rst), .active(active), .beat(beat),
    .edge_seen(edge_seen), .recovered(recovered)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst)      state_q <= LOS_CLEAR;
    else if (!en) state_q <= LOS_CLEAR;
    else begin
      case (state_q)
        LOS_CLEAR: if (expire)    state_q <= LOS_DOWN;
        LOS_DOWN:  if (recovered) state_q <= LOS_CLEAR;
        default:                  state_q <= LOS_CLEAR;
      endcase
    end
  end

  a_r1_raise: assert property (@(posedge clk) disable iff (rst)
    expire |=> los_int);
  a_r2_clear_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(los_int) |-> ($past(recovered) || $past(det_en_n)));
  a_r4_gated_low: assert property (@(posedge clk) disable iff (rst)
    los_flag |-> !out_bit);
  a_r5_disabled_off: assert property (@(posedge clk) disable iff (rst)
    det_en_n |=> !los_int);
endmodule

// File: tb/los_detect_tb_top.sv
`timescale 1ns/1ps
module los_detect_tb_top;
  localparam int RUN = 128;
  localparam int WIN = 128;
  localparam int MINE = 16;

  logic clk = 1'b0;
  logic rst, det_en_n, pol_sel, sd_flag;
  logic in_valid, in_bit, out_ready;
  logic in_ready, out_valid, out_bit, los_flag;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model state
  logic m_int, m_prev, m_hold, m_ov;
  int m_run, m_blk, m_edg;

  always #10 clk = ~clk;

  los_detect dut_i (
    .clk(clk), .rst(rst), .det_en_n(det_en_n), .pol_sel(pol_sel),
    .sd_flag(sd_flag), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit), .los_flag(los_flag)
  );

  function automatic logic exp_los();
    return m_int | ~(pol_sel ^ sd_flag);
  endfunction

  function automatic logic exp_out();
    return m_hold & ~exp_los();
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update(input logic beat, input logic b, input logic rdy);
    logic e;
    if (det_en_n) begin
      m_int = 1'b0; m_run = 0; m_blk = 0; m_edg = 0;
    end
    if (beat) begin
      e = (b != m_prev);
      m_prev = b;
      if (!det_en_n) begin
        if (!m_int) begin
          if (e) m_run = 0;
          else begin
            m_run++;
            if (m_run > RUN) begin
              m_int = 1'b1; m_run = 0; m_blk = 0; m_edg = 0;
            end
          end
        end else begin
          m_blk++;
          m_edg += int'(e);
          if (m_blk == WIN) begin
            if (m_edg > MINE) m_int = 1'b0;
            m_blk = 0; m_edg = 0;
          end
        end
      end
      m_hold = b;
      m_ov = 1'b1;
    end else if (rdy) begin
      m_ov = 1'b0;
    end
  endtask

  // one bit-clock cycle: compare, drive, predict
  task automatic step(input logic v, input logic b, input logic rdy, input string tag);
    logic er;
    #1;
    chk(tag, los_flag, exp_los());
    chk("R4 out_bit", out_bit, exp_out());
    chk("R9 out_valid", out_valid, m_ov);
    in_valid = v; in_bit = b; out_ready = rdy;
    #1;
    er = !m_ov || rdy;
    chk("R9 in_ready", in_ready, er);
    model_update(v && er, b, rdy);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic cur;
    int dens;
    void'($urandom(32'd2718));
    rst = 1'b1; det_en_n = 1'b0; pol_sel = 1'b1; sd_flag = 1'b0;
    in_valid = 1'b0; in_bit = 1'b0; out_ready = 1'b1;
    m_int = 0; m_prev = 0; m_hold = 0; m_ov = 0; m_run = 0; m_blk = 0; m_edg = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R8 reset state
    chk("R8 los after reset", los_flag, 1'b0);
    chk("R8 out_valid after reset", out_valid, 1'b0);

    // R1/R7: 128 quiet bits keep LOS low, the 129th raises it
    for (int i = 0; i < 128; i++) step(1'b1, 1'b0, 1'b1, "R1 run");
    #1 chk("R1 exactly 128 quiet bits", los_flag, 1'b0);
    step(1'b1, 1'b0, 1'b1, "R1 run");
    #1 chk("R1 129th quiet bit raises", los_flag, 1'b1);
    chk("R4 data forced low", out_bit, 1'b0);

    // R2/R3: window with exactly 16 edges keeps LOS
    cur = 1'b0;
    for (int i = 0; i < 128; i++) begin
      if (i < 16) cur = ~cur;
      step(1'b1, cur, 1'b1, "R3 window");
    end
    #1 chk("R2 sixteen edges insufficient", los_flag, 1'b1);
    // next window with 17 edges clears
    for (int i = 0; i < 128; i++) begin
      if (i < 17) cur = ~cur;
      step(1'b1, cur, 1'b1, "R3 window");
    end
    #1 chk("R2 seventeen edges clear", los_flag, 1'b0);
    step(1'b1, 1'b1, 1'b1, "R4 pass");
    #1 chk("R4 data passes when clear", out_bit, 1'b1);

    // R6: all polarity/flag combinations
    for (int c = 0; c < 4; c++) begin
      pol_sel = c[1]; sd_flag = c[0];
      #1 chk("R6 xnor combine", los_flag, ~(c[1] ^ c[0]));
      step(1'b1, 1'b1, 1'b1, "R6 ext");
    end
    pol_sel = 1'b1; sd_flag = 1'b0;

    // R5: disabled detector ignores a long quiet stretch
    det_en_n = 1'b1;
    for (int i = 0; i < 300; i++) step(1'b1, 1'b0, 1'b1, "R5 disabled");
    #1 chk("R5 no LOS while disabled", los_flag, 1'b0);
    det_en_n = 1'b0;
    for (int i = 0; i < 129; i++) step(1'b1, 1'b0, 1'b1, "R5 re-enabled");
    #1 chk("R5 fresh run after enable", los_flag, 1'b1);
    det_en_n = 1'b1;
    step(1'b1, 1'b0, 1'b1, "R5 disable clears");
    #1 chk("R5 disable clears LOS", los_flag, 1'b0);
    det_en_n = 1'b0;

    // R9: stall holds output, no bits accepted
    step(1'b1, 1'b1, 1'b1, "R9 load");
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, "R9 stall");
    #1 chk("R9 held bit", out_bit, 1'b1);
    chk("R9 ready low under stall", in_ready, 1'b0);
    step(1'b0, 1'b0, 1'b1, "R9 drain");
    step(1'b0, 1'b0, 1'b1, "R9 empty");

    // random traffic with varying transition density
    dens = 0;
    cur = 1'b0;
    for (int i = 0; i < 6000; i++) begin
      if ((i % 400) == 0) begin
        case ($urandom % 4)
          0: dens = 0;
          1: dens = 3;
          2: dens = 15;
          default: dens = 50;
        endcase
      end
      if (($urandom % 100) < dens) cur = ~cur;
      if (($urandom % 700) == 0) det_en_n = ~det_en_n;
      if (($urandom % 500) == 0) sd_flag = ~sd_flag;
      step(($urandom % 8) != 0, cur, ($urandom % 4) != 0, "R1 R2 random");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule